// File: doc/BRIEF.md
# Dual-Slot TDMA Transmit Gate

This block sits in front of a two-slot TDMA transmitter. For each slot it decides, every frame, whether queued payload may go out or whether idle filler must be sent in its place. It also produces the access-type bit carried on the common channel. It reports, per slot, how many whole frames still fit in that slot's queue.

The decision rests on three saturating counters. A global frame counter and one abort counter per slot all advance on each channel-access burst strobe while transmission runs. Payload is withheld during a start-up window after transmission begins. A slot is also muted for a fixed number of frames after an abort request names it. Starting or stopping transmission clears all counters and abort flags. The payload queues and the frame encoders are outside this block. It only sees their fill and free levels.

Top module: `tdma_tx_gate`

## Requirements
- R1: A pulse on `ctl_wr` loads the run state from `ctl_run` and clears the frame counter, both abort counters and both abort flags. It takes priority over a burst or abort presented in the same cycle.
- R2: Each `burst_stb` cycle while running advances the frame counter and both abort counters by one. When not running, a burst changes nothing.
- R3: Every counter saturates at 2**CNT_W-1 (63 by default) instead of wrapping.
- R4: `send_payload[s]` is 1 only when all of these hold: the block is running, the slot's fill is at least FRAME_BYTES (33), the frame counter is at least STARTUP_FRAMES (20), and the slot's abort counter is at least ABORT_FRAMES (6). Otherwise it is 0, meaning idle filler is sent. Slot 1 is bit 0 and slot 2 is bit 1.
- R5: An abort request with `abort_slot` = 1 (slot 1) or 2 (slot 2) clears only that slot's abort counter and sets only that slot's `abort_flag` bit. It takes priority over a burst in the same cycle.
- R6: An abort request with `abort_slot` = 0 or 3 changes no state. It drives `abort_err` high for exactly the following cycle.
- R7: `at_flag` is 0 while the frame counter is below STARTUP_FRAMES. From then on it is 1 exactly when the fill of the slot picked by `rx_slot` (0 = slot 1, 1 = slot 2) is non-zero.
- R8: `space_frames` for each slot equals that slot's free bytes divided, rounding down, by FRAME_BYTES+2 (35).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Start/stop strobe |
| ctl_run | input | 1 | Run value taken on `ctl_wr` |
| burst_stb | input | 1 | One pulse per channel-access burst |
| abort_req | input | 1 | Abort request strobe |
| abort_slot | input | 2 | Slot code of the abort (1 or 2 valid) |
| rx_slot | input | 1 | Slot being received, picks access-type source |
| fifo_fill | input | 2*FILL_W | Fill bytes, slot 1 in low bits |
| fifo_free | input | 2*FILL_W | Free bytes, slot 1 in low bits |
| send_payload | output | 2 | Per-slot payload release |
| at_flag | output | 1 | Access-type bit for the common channel |
| abort_flag | output | 2 | Per-slot abort flag |
| abort_err | output | 1 | Invalid abort slot code seen last cycle |
| space_frames | output | 2*FILL_W | Whole frames of free space per slot |

## Verification
The bench targets the exact threshold frames: burst 19 versus 20 for start-up, and the sixth burst after an abort. A design with an off-by-one compare would release payload one frame early or late. Fills of 32, 33 and 34 bytes check the full-frame test. Running past 63 bursts shows that a counter which wrapped to zero would mute payload again. Same-cycle collisions of start, abort and burst show whether a design gives the wrong event priority, letting a slot's mute window restart late or counters survive a stop. Invalid slot codes 0 and 3 must leave both slots untouched and raise the error for one cycle only.

// File: rtl/tdma_gate_pkg.sv
package tdma_gate_pkg;

   localparam int SLOTS = 2;

   typedef enum logic [1:0] {
      SLOT_CODE_NONE  = 2'd0,
      SLOT_CODE_FIRST = 2'd1,
      SLOT_CODE_SECOND = 2'd2,
      SLOT_CODE_BAD   = 2'd3
   } slot_code_e;

   // One-hot slot select for a slot code; all zeros when the code is invalid.
   function automatic logic [SLOTS-1:0] slot_onehot(input logic [1:0] code);
      logic [SLOTS-1:0] sel;
      case (slot_code_e'(code))
         SLOT_CODE_FIRST:  sel = 2'b01;
         SLOT_CODE_SECOND: sel = 2'b10;
         default:          sel = 2'b00;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/tdma_sat_counter.sv
module tdma_sat_counter #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc && (count != MAX_VAL))
         count <= count + 1'b1;
   end

endmodule

// File: rtl/tdma_slot_gate.sv
module tdma_slot_gate #(
   parameter int FILL_W       = 10,
   parameter int CNT_W        = 6,
   parameter int FRAME_BYTES  = 33,
   parameter int ABORT_FRAMES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_clr,
   input  logic              burst_inc,
   input  logic              abort_hit,
   input  logic              global_ok,
   input  logic [FILL_W-1:0] fill,
   input  logic [FILL_W-1:0] free,
   output logic              send,
   output logic              aflag,
   output logic [FILL_W-1:0] space
);

   localparam logic [FILL_W-1:0] FRAME_LVL = FILL_W'(FRAME_BYTES);
   localparam logic [FILL_W-1:0] SLOT_DIV  = FILL_W'(FRAME_BYTES + 2);
   localparam logic [CNT_W-1:0]  MUTE_LVL  = CNT_W'(ABORT_FRAMES);

   logic [CNT_W-1:0] abort_cnt;
   logic             aflag_q;

   tdma_sat_counter #(.W(CNT_W)) u_abort_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl_clr | abort_hit),
      .inc   (burst_inc),
      .count (abort_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         aflag_q <= 1'b0;
      else if (ctl_clr)
         aflag_q <= 1'b0;
      else if (abort_hit)
         aflag_q <= 1'b1;
   end

   always_comb begin
      send  = global_ok && (fill >= FRAME_LVL) && (abort_cnt >= MUTE_LVL);
      aflag = aflag_q;
      space = free / SLOT_DIV;
   end

endmodule

// File: rtl/tdma_tx_gate.sv
module tdma_tx_gate
   import tdma_gate_pkg::*;
#(
   parameter int FILL_W         = 10,
   parameter int CNT_W          = 6,
   parameter int FRAME_BYTES    = 33,
   parameter int STARTUP_FRAMES = 20,
   parameter int ABORT_FRAMES   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_wr,
   input  logic                    ctl_run,
   input  logic                    burst_stb,
   input  logic                    abort_req,
   input  logic [1:0]              abort_slot,
   input  logic                    rx_slot,
   input  logic [2*FILL_W-1:0]     fifo_fill,
   input  logic [2*FILL_W-1:0]     fifo_free,
   output logic [1:0]              send_payload,
   output logic                    at_flag,
   output logic [1:0]              abort_flag,
   output logic                    abort_err,
   output logic [2*FILL_W-1:0]     space_frames
);

   localparam int               CNT_MAX   = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] START_LVL = CNT_W'(STARTUP_FRAMES);

   if (STARTUP_FRAMES > CNT_MAX) begin : g_bad_startup
      $error("STARTUP_FRAMES does not fit in CNT_W bits");
   end
   if (ABORT_FRAMES > CNT_MAX) begin : g_bad_abort
      $error("ABORT_FRAMES does not fit in CNT_W bits");
   end
   if (FRAME_BYTES + 2 >= (1 << FILL_W)) begin : g_bad_frame
      $error("FRAME_BYTES too large for FILL_W");
   end

   logic              run_q;
   logic              err_q;
   logic [CNT_W-1:0]  frame_cnt;
   logic [SLOTS-1:0]  abort_sel;
   logic              burst_inc;
   logic              global_ok;
   logic              started;
   logic [FILL_W-1:0] rx_fill;

   always_comb begin
      abort_sel = abort_req ? slot_onehot(abort_slot) : '0;
      burst_inc = burst_stb && run_q;
      started   = (frame_cnt >= START_LVL);
      global_ok = run_q && started;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (ctl_wr)
            run_q <= ctl_run;
         err_q <= abort_req && (slot_onehot(abort_slot) == '0);
      end
   end

   tdma_sat_counter #(.W(CNT_W)) u_frame_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl_wr),
      .inc   (burst_inc),
      .count (frame_cnt)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      tdma_slot_gate #(
         .FILL_W       (FILL_W),
         .CNT_W        (CNT_W),
         .FRAME_BYTES  (FRAME_BYTES),
         .ABORT_FRAMES (ABORT_FRAMES)
      ) u_gate (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_clr   (ctl_wr),
         .burst_inc (burst_inc),
         .abort_hit (abort_sel[s]),
         .global_ok (global_ok),
         .fill      (fifo_fill[s*FILL_W +: FILL_W]),
         .free      (fifo_free[s*FILL_W +: FILL_W]),
         .send      (send_payload[s]),
         .aflag     (abort_flag[s]),
         .space     (space_frames[s*FILL_W +: FILL_W])
      );
   end

   always_comb begin
      rx_fill   = rx_slot ? fifo_fill[FILL_W +: FILL_W] : fifo_fill[0 +: FILL_W];
      at_flag   = started && (rx_fill != '0);
      abort_err = err_q;
   end

endmodule

// File: rtl/tdma_tx_gate_chk.sv
module tdma_tx_gate_chk #(
   parameter int CNT_W          = 6,
   parameter int STARTUP_FRAMES = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             ctl_run,
   input logic             burst_stb,
   input logic             abort_req,
   input logic [1:0]       abort_slot,
   input logic [1:0]       send_payload,
   input logic             at_flag,
   input logic [1:0]       abort_flag,
   input logic             abort_err,
   input logic [CNT_W-1:0] frame_cnt,
   input logic             run_q
);

   localparam logic [CNT_W-1:0] MAX_VAL   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] START_LVL = CNT_W'(STARTUP_FRAMES);

   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (frame_cnt == '0) && (abort_flag == 2'b00) && (run_q == $past(ctl_run)));

   assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_stb && run_q && !ctl_wr && frame_cnt != MAX_VAL)
         |=> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && !(burst_stb && run_q)) |=> $stable(frame_cnt));

   assert_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_cnt == MAX_VAL && !ctl_wr) |=> frame_cnt == MAX_VAL);

   assert_startup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_cnt < START_LVL || !run_q) |-> send_payload == 2'b00);

   assert_abort_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && abort_slot == 2'd1 && !ctl_wr) |=> abort_flag[0] && !send_payload[0]);

   assert_abort_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && abort_slot == 2'd2 && !ctl_wr) |=> abort_flag[1] && !send_payload[1]);

   assert_bad_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && (abort_slot == 2'd0 || abort_slot == 2'd3)) |=> abort_err);

   assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_req |=> !abort_err);

   assert_at_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_cnt < START_LVL) |-> !at_flag);

endmodule

bind tdma_tx_gate tdma_tx_gate_chk #(
   .CNT_W          (CNT_W),
   .STARTUP_FRAMES (STARTUP_FRAMES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_run      (ctl_run),
   .burst_stb    (burst_stb),
   .abort_req    (abort_req),
   .abort_slot   (abort_slot),
   .send_payload (send_payload),
   .at_flag      (at_flag),
   .abort_flag   (abort_flag),
   .abort_err    (abort_err),
   .frame_cnt    (frame_cnt),
   .run_q        (run_q)
);

// File: tb/tdma_tx_gate_tb.sv
`timescale 1ns/1ps
module tdma_tx_gate_tb;

   localparam int FILL_W = 10;
   localparam int CNT_W  = 6;
   localparam int FB     = 33;
   localparam int START  = 20;
   localparam int MUTE   = 6;
   localparam int CMAX   = (1 << CNT_W) - 1;
   localparam int FMAX   = (1 << FILL_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, ctl_run = 1'b0, burst_stb = 1'b0, abort_req = 1'b0;
   logic [1:0] abort_slot = 2'd0;
   logic rx_slot = 1'b0;
   logic [FILL_W-1:0] fill_a = '0, fill_b = '0, free_a = '0, free_b = '0;
   logic [1:0] send_payload, abort_flag;
   logic at_flag, abort_err;
   logic [2*FILL_W-1:0] space_frames;

   always #2.5 clk = ~clk;

   tdma_tx_gate #(
      .FILL_W(FILL_W), .CNT_W(CNT_W), .FRAME_BYTES(FB),
      .STARTUP_FRAMES(START), .ABORT_FRAMES(MUTE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
      .burst_stb(burst_stb), .abort_req(abort_req), .abort_slot(abort_slot),
      .rx_slot(rx_slot), .fifo_fill({fill_b, fill_a}), .fifo_free({free_b, free_a}),
      .send_payload(send_payload), .at_flag(at_flag), .abort_flag(abort_flag),
      .abort_err(abort_err), .space_frames(space_frames)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;
   int fc = 0, run_m = 0, err_m = 0;
   int ac[2] = '{0, 0};
   int flg[2] = '{0, 0};
   int fills[6] = '{0, 1, FB-1, FB, FB+1, FMAX};

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (fc=%0d ac0=%0d ac1=%0d)",
                  req, act, exp, fc, ac[0], ac[1]);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   // Payload, access-type, abort flag and error outputs against the model.
   task automatic verify_state(input string tag);
      check({tag, " R5 abort_flag slot1"}, int'(abort_flag[0]), flg[0]);
      check({tag, " R5 abort_flag slot2"}, int'(abort_flag[1]), flg[1]);
      check({tag, " R6 abort_err"}, int'(abort_err), err_m);
      foreach (fills[i]) begin
         foreach (fills[j]) begin
            for (int r = 0; r < 2; r++) begin
               int exp_s0, exp_s1, exp_at, rxf;
               fill_a = FILL_W'(fills[i]);
               fill_b = FILL_W'(fills[j]);
               rx_slot = r[0];
               #0.05;
               exp_s0 = (run_m != 0 && fills[i] >= FB && fc >= START && ac[0] >= MUTE) ? 1 : 0;
               exp_s1 = (run_m != 0 && fills[j] >= FB && fc >= START && ac[1] >= MUTE) ? 1 : 0;
               rxf = (r == 0) ? fills[i] : fills[j];
               exp_at = (fc >= START && rxf != 0) ? 1 : 0;
               check({tag, " R4 send slot1"}, int'(send_payload[0]), exp_s0);
               check({tag, " R4 send slot2"}, int'(send_payload[1]), exp_s1);
               check({tag, " R7 at_flag"}, int'(at_flag), exp_at);
            end
         end
      end
   endtask

   task automatic step(input string tag, input bit wr, input bit runv,
                       input bit burst, input bit ab, input int code);
      ctl_wr = wr; ctl_run = runv; burst_stb = burst;
      abort_req = ab; abort_slot = code[1:0];
      @(posedge clk);
      #0.5;
      ctl_wr = 1'b0; burst_stb = 1'b0; abort_req = 1'b0; abort_slot = 2'd0;
      err_m = (ab && code != 1 && code != 2) ? 1 : 0;
      if (wr) begin
         run_m = runv; fc = 0; ac[0] = 0; ac[1] = 0; flg[0] = 0; flg[1] = 0;
      end else begin
         if (burst && run_m != 0) begin
            fc = sat_inc(fc); ac[0] = sat_inc(ac[0]); ac[1] = sat_inc(ac[1]);
         end
         if (ab && (code == 1 || code == 2)) begin
            ac[code-1] = 0; flg[code-1] = 1;
         end
      end
      verify_state(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      verify_state("reset R1");

      // R8 space sweep over every free level
      for (int f = 0; f <= FMAX; f++) begin
         free_a = FILL_W'(f);
         free_b = FILL_W'(FMAX - f);
         #0.05;
         check("R8 space slot1", int'(space_frames[0 +: FILL_W]), f / (FB + 2));
         check("R8 space slot2", int'(space_frames[FILL_W +: FILL_W]), (FMAX - f) / (FB + 2));
      end

      // R2: bursts while stopped do nothing
      for (int k = 0; k < 3; k++) step("idle burst R2", 0, 0, 1, 0, 0);
      step("start R1", 1, 1, 0, 0, 0);
      for (int k = 0; k < 25; k++) step("run burst R2", 0, 0, 1, 0, 0);
      step("abort slot1 R5", 0, 0, 0, 1, 1);
      step("bad code0 R6", 0, 0, 0, 1, 0);
      step("bad code3 R6", 0, 0, 0, 1, 3);
      step("err clears R6", 0, 0, 0, 0, 0);
      for (int k = 0; k < 4; k++) step("mute window R4", 0, 0, 1, 0, 0);
      step("abort slot2 with burst R5", 0, 0, 1, 1, 2);
      for (int k = 0; k < 8; k++) step("after abort R4", 0, 0, 1, 0, 0);
      step("restart beats burst R1", 1, 1, 1, 1, 1);
      for (int k = 0; k < 70; k++) step("saturate R3", 0, 0, 1, 0, 0);
      step("abort slot2 at max R5", 0, 0, 0, 1, 2);
      for (int k = 0; k < 7; k++) step("remute R4", 0, 0, 1, 0, 0);
      step("stop R1", 1, 0, 0, 0, 0);
      for (int k = 0; k < 3; k++) step("stopped burst R2", 0, 0, 1, 0, 0);
      step("start again R1", 1, 1, 0, 0, 0);
      for (int k = 0; k < 21; k++) step("second run R7", 0, 0, 1, 0, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule